// File: doc/BRIEF.md
# Per-Rank Four-Activate Window Limiter

This block sits beside a DRAM command scheduler and tells it, for every rank, whether a row-activate (ACT) command may be issued in the current cycle. Two rules feed the decision. First, a rank may receive no more than four ACTs inside any sliding window whose length is the programmed four-activate window (tFAW). Second, two ACTs to the same rank must be at least the programmed ACT-to-ACT spacing (tRRD) apart.

The scheduler presents each issued ACT as a one-cycle strobe with the target rank index. For each rank the block keeps a ring of four age counters, one for each of the most recent ACTs. A counter starts at one on the clock edge that records the ACT, then rises by one per cycle and stops at 63. A further ACT is allowed once the newest entry has aged at least tRRD cycles and, if all four entries are occupied, the oldest has aged at least the effective window. Before use, the programmed window is forced into the range from 4*tRRD up to 63 cycles. The window field is 8 bits wide; the value loaded into it at power-up is 16 cycles. Both timing values are counted in DRAM clock cycles.

Top module: `faw_act_limiter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every bit of `act_ok` is 1. Reset discards all recorded ACTs, including a history that was full when reset arrived.
- R2: After an ACT to rank r is presented in cycle t, with tRRD = D ≥ 1, `act_ok[r]` is 0 in cycles t+1 to t+D-1, provided the window does not block it longer.
- R3: An ACT to one rank does not clear `act_ok` for any other rank.
- R4: Once four ACTs to a rank are recorded, a fifth is permitted only when the oldest of them is at least the effective window old. With the earliest ACT in cycle t1 and each later one issued as soon as it is allowed, the fifth comes at t1 + max(W, 4*max(D,1)).
- R5: A programmed window above 63 acts as 63.
- R6: A programmed window below 4*tRRD acts as 4*tRRD.
- R7: The window slides. After the fifth ACT, the next ACT waits until the second-oldest recorded ACT is at least the effective window old, and also until tRRD has passed since the fifth.
- R8: With tRRD of 0 or 1, an ACT to the same rank is permitted in the very next cycle, as long as the window allows it.
- R9: The block records every presented ACT, including one presented while `act_ok` for that rank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An ACT is issued in this cycle |
| act_rank | input | RANK_W | Rank that the ACT targets |
| cfg_faw | input | FAW_W (8) | Programmed four-activate window, in cycles |
| cfg_rrd | input | RRD_W (4) | Programmed minimum ACT-to-ACT spacing, in cycles |
| act_ok | output | NUM_RANKS | One bit per rank: an ACT to that rank is allowed now |

## Verification
A wrong age counter, ring pointer or valid flag shows at the ports as an ACT that is permitted too early or held back too long. A spacing fault appears within tRRD cycles of an ACT. A window fault appears only at the fifth or later ACT to a rank, so at most 63 cycles after the oldest entry was written. The bench therefore measures the exact cycle distance between ACTs issued as soon as they are allowed. It checks both clamps, the sliding of the window past the fifth ACT, independence between ranks, and clearing of a full history by reset.

// File: rtl/faw_pkg.sv
package faw_pkg;

    // Upper bound on the effective window, in cycles.
    localparam int FAW_MAX = 63;
    // Number of ACTs allowed inside one window.
    localparam int SLOTS   = 4;
    localparam int AGE_W   = $clog2(FAW_MAX + 1);
    localparam int PTR_W   = $clog2(SLOTS);
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(FAW_MAX);

    typedef logic [AGE_W-1:0] age_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        age_t [SLOTS-1:0] age;
        logic [SLOTS-1:0] vld;
        ptr_t             ptr;
    } hist_t;

endpackage

// File: rtl/faw_window_clamp.sv
module faw_window_clamp
    import faw_pkg::*;
#(
    parameter int FAW_W = 8,
    parameter int RRD_W = 4
) (
    input  logic [FAW_W-1:0] cfg_faw,
    input  logic [RRD_W-1:0] cfg_rrd,
    output age_t             faw_eff
);
    localparam int LO_W = RRD_W + 2;

    logic [LO_W-1:0] floor_v;
    age_t            capped;

    always_comb begin
        floor_v = {cfg_rrd, 2'b00};
        if (cfg_faw > FAW_W'(FAW_MAX)) begin
            capped = AGE_SAT;
        end else begin
            capped = AGE_W'(cfg_faw);
        end
        if (LO_W'(capped) < floor_v) begin
            faw_eff = AGE_W'(floor_v);
        end else begin
            faw_eff = capped;
        end
    end

endmodule

// File: rtl/faw_rank_history.sv
module faw_rank_history
    import faw_pkg::*;
#(
    parameter int RRD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  age_t             faw_eff,
    input  logic [RRD_W-1:0] rrd_eff,
    output logic             act_ok
);
    hist_t hist_d, hist_q;
    ptr_t  last_ptr;
    logic  full;
    logic  rrd_ok;
    logic  faw_ok;

    // Next-state computation.
    always_comb begin
        hist_d = hist_q;
        for (int k = 0; k < SLOTS; k++) begin
            if (hist_q.vld[k] && hist_q.age[k] != AGE_SAT) begin
                hist_d.age[k] = hist_q.age[k] + AGE_W'(1);
            end
        end
        if (act_hit) begin
            hist_d.age[hist_q.ptr] = AGE_W'(1);
            hist_d.vld[hist_q.ptr] = 1'b1;
            hist_d.ptr             = hist_q.ptr + PTR_W'(1);
        end
    end

    // Permission derived from the registered history.
    always_comb begin
        last_ptr = hist_q.ptr - PTR_W'(1);
        full     = &hist_q.vld;
        rrd_ok   = !hist_q.vld[last_ptr] ||
                   (hist_q.age[last_ptr] >= AGE_W'(rrd_eff));
        faw_ok   = !full || (hist_q.age[hist_q.ptr] >= faw_eff);
        act_ok   = rrd_ok && faw_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // R2: an ACT with spacing above one blocks the next cycle
    a_r2_rrd_block: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit && rrd_eff > RRD_W'(1) |=> !act_ok || !$stable(rrd_eff));

    // R9: every presented ACT lands in the slot the pointer named
    a_r9_slot_record: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> hist_q.vld[$past(hist_q.ptr)] &&
                    hist_q.age[$past(hist_q.ptr)] == AGE_W'(1));

    // R1: an empty history never withholds permission
    a_r1_empty_permits: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q.vld == '0 |-> act_ok);

endmodule

// File: rtl/faw_act_limiter.sv
module faw_act_limiter
    import faw_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int FAW_W     = 8,
    parameter int RRD_W     = 4,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    input  logic [FAW_W-1:0]     cfg_faw,
    input  logic [RRD_W-1:0]     cfg_rrd,
    output logic [NUM_RANKS-1:0] act_ok
);
    age_t faw_eff;

    faw_window_clamp #(
        .FAW_W (FAW_W),
        .RRD_W (RRD_W)
    ) clamp_i (
        .cfg_faw (cfg_faw),
        .cfg_rrd (cfg_rrd),
        .faw_eff (faw_eff)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic hit;
        assign hit = act_valid && (act_rank == RANK_W'(r));

        faw_rank_history #(
            .RRD_W (RRD_W)
        ) hist_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_hit (hit),
            .faw_eff (faw_eff),
            .rrd_eff (cfg_rrd),
            .act_ok  (act_ok[r])
        );

        // R3: a rank that receives no ACT keeps its permission while timing is steady
        a_r3_idle_rank_keeps_permit: assert property (@(posedge clk) disable iff (!rst_n)
            !hit && act_ok[r] |=> act_ok[r] || !$stable(cfg_faw) || !$stable(cfg_rrd));
    end

endmodule

// File: tb/faw_act_limiter_tb_top.sv
`timescale 1ns/1ps
module faw_act_limiter_tb_top;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_valid = 1'b0;
    logic [1:0]    act_rank = '0;
    logic [7:0]    cfg_faw = 8'd16;
    logic [3:0]    cfg_rrd = 4'd4;
    logic [NR-1:0] act_ok;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    faw_act_limiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .act_rank  (act_rank),
        .cfg_faw   (cfg_faw),
        .cfg_rrd   (cfg_rrd),
        .act_ok    (act_ok)
    );

    // {faw, rrd, expected same-rank gap, expected distance from 1st to 5th ACT}
    localparam int VEC [9][4] = '{
        '{16,  4,  4, 16},   // R4 default window
        '{20,  4,  4, 20},   // R4
        '{10,  4,  4, 16},   // R6 floor
        '{100, 2,  2, 63},   // R5 ceiling
        '{8,   1,  1,  8},   // R8
        '{0,   0,  1,  4},   // R8 / R6
        '{63, 15, 15, 63},   // R5 edge
        '{40, 15, 15, 60},   // R6
        '{3,   1,  1,  4}    // R6
    };

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        act_valid = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic act_wait(input int rk, output int t);
        int w = 0;
        while (!act_ok[rk] && w < 300) begin
            step();
            w++;
        end
        if (w >= 300) check(1'b0, "watchdog wait", w, 0);
        t = cyc;
        act_rank = 2'(rk);
        act_valid = 1'b1;
        step();
        act_valid = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t [6];
        int tt;
        // R1: reset state
        rst_n = 1'b0;
        step();
        check(act_ok == '1, "R1 during reset", int'(act_ok), 15);
        do_reset();
        check(act_ok == '1, "R1 after reset", int'(act_ok), 15);

        // Table walk on rank 0
        for (int v = 0; v < 9; v++) begin
            cfg_faw = 8'(VEC[v][0]);
            cfg_rrd = 4'(VEC[v][1]);
            do_reset();
            for (int a = 0; a < 5; a++) begin
                act_wait(0, t[a]);
                if (a == 0) begin
                    check(act_ok[3:1] == 3'b111, "R3 other ranks", int'(act_ok[3:1]), 7);
                end
            end
            check(t[1] - t[0] == VEC[v][2], "R2/R8 spacing", t[1] - t[0], VEC[v][2]);
            check(t[3] - t[2] == VEC[v][2], "R2/R8 spacing", t[3] - t[2], VEC[v][2]);
            check(t[4] - t[0] == VEC[v][3], "R4/R5/R6 fifth ACT", t[4] - t[0], VEC[v][3]);
        end

        // R7: sliding window, faw 20 rrd 2, ACTs at 0,10,12,14 -> 5th at 20, 6th at 30
        cfg_faw = 8'd20;
        cfg_rrd = 4'd2;
        do_reset();
        act_wait(0, t[0]);
        repeat (9) step();
        check(act_ok[0] == 1'b1, "R7 idle permit", int'(act_ok[0]), 1);
        act_wait(0, t[1]);
        act_wait(0, t[2]);
        act_wait(0, t[3]);
        act_wait(0, t[4]);
        act_wait(0, t[5]);
        check(t[3] - t[0] == 14, "R7 fourth", t[3] - t[0], 14);
        check(t[4] - t[0] == 20, "R7 fifth", t[4] - t[0], 20);
        check(t[5] - t[0] == 30, "R7 sixth", t[5] - t[0], 30);

        // R3: ACT on rank 2 blocks only rank 2
        cfg_faw = 8'd16;
        cfg_rrd = 4'd4;
        do_reset();
        act_wait(2, tt);
        check(act_ok == 4'b1011, "R3 isolation", int'(act_ok), 11);
        act_wait(1, tt);
        check(act_ok == 4'b1001, "R3 second rank", int'(act_ok), 9);

        // R9: ACT presented while blocked is still recorded (restarts spacing)
        do_reset();
        act_wait(0, t[0]);
        step();
        act_rank = 2'd0;
        act_valid = 1'b1;          // blocked ACT at t0+2
        step();
        act_valid = 1'b0;
        act_wait(0, t[1]);
        check(t[1] - t[0] == 6, "R9 blocked ACT recorded", t[1] - t[0], 6);

        // R1: full history cleared by reset
        cfg_faw = 8'd63;
        cfg_rrd = 4'd1;
        do_reset();
        for (int a = 0; a < 4; a++) act_wait(3, tt);
        check(act_ok[3] == 1'b0, "R4 history full", int'(act_ok[3]), 0);
        do_reset();
        check(act_ok == '1, "R1 history cleared", int'(act_ok), 15);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule